// File: doc/BRIEF.md
# Suspend and Wake-up Sequencer

This block sequences a controller's entry into and exit from a low-power suspend state. Software requests suspend with a single control write that carries a suspend bit and a run bit. The sequencer then stops the core clock and the timers, and after that it releases the oscillator. While suspended it watches a small set of pending interrupt flags and the level of the D- data line. A low level on D- means bus activity. The line is brought through a two-flop synchroniser before use.

When a wake source fires and the run bit was set, the sequencer turns the oscillator back on. It waits for the oscillator-stable input, then counts a resume delay. The delay is chosen from the clock source and an external-clock long-delay setting. The block then restores the clock. Interrupt service stays held off until the first instruction after the suspend write has completed. The suspend flag clears by itself when the sequencer returns to normal running.

The block runs from an always-on clock. The wake flags it receives are already qualified by their individual enables. No global interrupt-sense bit takes part in the wake decision.

Top module: `suspend_seq`

## Requirements
- R1: After reset, clk_en, osc_en and timers_en are 1, and irq_holdoff and suspend_flag are 0.
- R2: A ctl_wr with ctl_suspend=1 while running drives clk_en and timers_en to 0 from the next cycle, and osc_en to 0 one cycle later. A ctl_wr with ctl_suspend=0 leaves all outputs unchanged.
- R3: If a wake source is already active at the suspend write, the sequencer still spends at least one cycle with osc_en at 0 before waking.
- R4: Wake sources are irq_wake bit 0 (GPIO), bit 1 (wake timer), bit 2 (SPI slave), and dm_line at 0. While suspended, osc_en returns to 1 one cycle after an irq_wake bit is seen high, or three cycles after dm_line goes low because of the two-flop synchroniser.
- R5: If the suspend write had ctl_run=0, no wake source ever brings osc_en back to 1 until reset.
- R6: While the oscillator is not stable, clk_en stays 0 no matter how long osc_stable remains low.
- R7: clk_en returns to 1 exactly N+1 cycles after osc_stable is first presented high while waiting. N is INT_DELAY when clk_ext=0, EXT_DELAY when clk_ext=1 and ext_long_dly=0, and EXT_LONG_DELAY when both are 1. ext_long_dly has no effect with clk_ext=0.
- R8: irq_holdoff is 1 from the cycle clk_en returns until the cycle after instr_done is seen, and clk_en stays 1 throughout.
- R9: suspend_flag becomes 1 on the suspend write, stays 1 through resume, and clears in the same cycle irq_holdoff falls.
- R10: clk_en is never 1 while osc_en is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_suspend | input | 1 | Suspend bit of the write data |
| ctl_run | input | 1 | Run bit of the write data |
| irq_wake | input | NUM_IRQ_SRC | Enabled-and-pending flags: bit 0 GPIO, bit 1 wake timer, bit 2 SPI slave |
| dm_line | input | 1 | Raw D- line level; low requests wake |
| osc_stable | input | 1 | Oscillator reports a stable output |
| clk_ext | input | 1 | 1 = external clock source selected |
| ext_long_dly | input | 1 | Long resume delay for external clock |
| instr_done | input | 1 | Core has completed an instruction |
| clk_en | output | 1 | Core clock enable |
| osc_en | output | 1 | Oscillator enable |
| timers_en | output | 1 | Free-running and watchdog timer enable |
| irq_holdoff | output | 1 | Blocks interrupt service |
| suspend_flag | output | 1 | Suspend bit as seen by software |

## Verification
The bench raises a wake flag before the suspend write. A design that skipped suspend in that case would never drop osc_en. It clears the run bit and fires wakes. A design that ignored the run bit would bring the oscillator back. It drives D- low and expects two extra cycles of latency, so a design that used the raw line or a single flop is caught. It measures the exact resume delay for each clock selection, including the internal clock with the long setting set, which must stay short. It holds off instr_done for several cycles, so a hold-off that lasted a fixed single cycle would expose an interrupt before the first instruction.

// File: rtl/suspend_seq_pkg.sv
// Shared types for the suspend sequencer.
// Assumes: only the sequencer and its checker use these encodings.
package suspend_seq_pkg;

    typedef enum logic [2:0] {
        SQ_RUN      = 3'd0,  // normal operation
        SQ_ENTER    = 3'd1,  // clock gated, oscillator still on
        SQ_SLEEP    = 3'd2,  // everything stopped, watching wake sources
        SQ_OSCWAIT  = 3'd3,  // oscillator restarted, waiting for stable
        SQ_DLYWAIT  = 3'd4,  // counting the resume delay
        SQ_FIRSTOP  = 3'd5   // clock back, interrupts held for one instruction
    } seq_state_e;

endpackage

// File: rtl/sseq_sync.sv
// Multi-flop synchroniser for one asynchronous level.
// Assumes: the input is a slow level, so no pulse needs to be caught.
// Reset value is a parameter so that an idle-high line reads idle.
module sseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the sampled level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sseq_wake.sv
// Merges the wake sources into one request.
// Assumes: every irq flag is already qualified by its own enable,
// and no global interrupt-sense bit takes part.
module sseq_wake #(
    parameter int NUM_SRC = 3
) (
    input  logic [NUM_SRC-1:0] irq_pend,
    input  logic               dm_low,
    output logic               wake
);
    logic [NUM_SRC:0] src;

    // Gather interrupt flags and bus activity into one vector.
    always_comb begin
        src = {dm_low, irq_pend};
    end

    assign wake = |src;
endmodule

// File: rtl/sseq_delay.sv
// Down-counter that times the resume delay.
// Assumes: load and dec are never asserted in the same cycle.
// zero reports that the count has reached 0.
module sseq_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Load the selected delay, or count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (load)              cnt_q <= load_val;
        else if (dec && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/suspend_seq.sv
// Suspend and wake-up sequencer.
// Runs from an always-on clock. It gates the core clock and the timers on a
// suspend write, and stops the oscillator. It wakes on a qualified interrupt
// flag or a low D- line. After the oscillator is stable it waits a selected
// delay, then restores the clock. Interrupt service stays held off until the
// first instruction has completed.
// Assumes: osc_stable, instr_done and the irq flags are synchronous to clk.
// dm_line is asynchronous.
module suspend_seq
    import suspend_seq_pkg::*;
#(
    parameter int NUM_IRQ_SRC    = 3,
    parameter int INT_DELAY      = 16,
    parameter int EXT_DELAY      = 32,
    parameter int EXT_LONG_DELAY = 128
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_wr,
    input  logic                   ctl_suspend,
    input  logic                   ctl_run,
    input  logic [NUM_IRQ_SRC-1:0] irq_wake,
    input  logic                   dm_line,
    input  logic                   osc_stable,
    input  logic                   clk_ext,
    input  logic                   ext_long_dly,
    input  logic                   instr_done,
    output logic                   clk_en,
    output logic                   osc_en,
    output logic                   timers_en,
    output logic                   irq_holdoff,
    output logic                   suspend_flag
);
    localparam int MAX_EXT   = (EXT_LONG_DELAY > EXT_DELAY) ? EXT_LONG_DELAY : EXT_DELAY;
    localparam int MAX_DELAY = (MAX_EXT > INT_DELAY) ? MAX_EXT : INT_DELAY;
    localparam int DCW       = $clog2(MAX_DELAY + 1);

    seq_state_e     state_q, state_d;
    logic           run_q;
    logic           susp_q;
    logic           dm_sync;
    logic           dm_low;
    logic           wake_req;
    logic           dly_zero;
    logic           dly_load;
    logic           dly_dec;
    logic [DCW-1:0] dly_pick;

    sseq_sync #(.STAGES(2), .RST_VAL(1'b1)) u_dm_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (dm_line),
        .dout  (dm_sync)
    );

    assign dm_low = ~dm_sync;

    sseq_wake #(.NUM_SRC(NUM_IRQ_SRC)) u_wake (
        .irq_pend (irq_wake),
        .dm_low   (dm_low),
        .wake     (wake_req)
    );

    // Choose the resume delay from the clock source and the long setting.
    always_comb begin
        if (!clk_ext)          dly_pick = DCW'(INT_DELAY - 1);
        else if (ext_long_dly) dly_pick = DCW'(EXT_LONG_DELAY - 1);
        else                   dly_pick = DCW'(EXT_DELAY - 1);
    end

    assign dly_load = (state_q == SQ_OSCWAIT) && osc_stable;
    assign dly_dec  = (state_q == SQ_DLYWAIT);

    sseq_delay #(.W(DCW)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_pick),
        .dec      (dly_dec),
        .zero     (dly_zero)
    );

    // Next-state logic of the sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_RUN:     if (ctl_wr && ctl_suspend) state_d = SQ_ENTER;
            SQ_ENTER:   state_d = SQ_SLEEP;
            SQ_SLEEP:   if (run_q && wake_req) state_d = SQ_OSCWAIT;
            SQ_OSCWAIT: if (osc_stable) state_d = SQ_DLYWAIT;
            SQ_DLYWAIT: if (dly_zero) state_d = SQ_FIRSTOP;
            SQ_FIRSTOP: if (instr_done) state_d = SQ_RUN;
            default:    state_d = SQ_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_RUN;
        else        state_q <= state_d;
    end

    // Software-visible bits: captured on a write, suspend cleared on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            susp_q <= 1'b0;
        end else if (state_q == SQ_RUN && ctl_wr) begin
            run_q  <= ctl_run;
            susp_q <= ctl_suspend;
        end else if (state_q == SQ_FIRSTOP && instr_done) begin
            susp_q <= 1'b0;
        end
    end

    // Output decode from the state register.
    always_comb begin
        clk_en       = (state_q == SQ_RUN) || (state_q == SQ_FIRSTOP);
        timers_en    = clk_en;
        osc_en       = (state_q != SQ_SLEEP);
        irq_holdoff  = (state_q == SQ_FIRSTOP);
        suspend_flag = susp_q;
    end
endmodule

// File: rtl/sseq_checker.sv
// Property checker for suspend_seq, attached by bind below.
// Assumes: its state and run inputs mirror the sequencer's registers.
module sseq_checker
    import suspend_seq_pkg::*;
#(
    parameter int NUM_IRQ_SRC = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ctl_wr,
    input logic                   ctl_suspend,
    input logic [NUM_IRQ_SRC-1:0] irq_wake,
    input logic                   dm_low,
    input logic                   osc_stable,
    input logic                   instr_done,
    input logic                   clk_en,
    input logic                   osc_en,
    input logic                   timers_en,
    input logic                   irq_holdoff,
    input logic                   suspend_flag,
    input seq_state_e             state,
    input logic                   run_q
);
    assert_gate_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_RUN && ctl_wr && ctl_suspend) |=> (!clk_en && !timers_en));

    assert_osc_off_after_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_ENTER) |=> !osc_en);

    assert_wake_restarts_osc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_SLEEP && run_q && ((|irq_wake) || dm_low)) |=> osc_en);

    assert_no_run_no_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !run_q) |=> !osc_en);

    assert_wait_unstable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_OSCWAIT && !osc_stable) |=> !clk_en);

    assert_holdoff_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_holdoff && !instr_done) |=> (irq_holdoff && clk_en));

    assert_clock_returns_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en) |-> irq_holdoff);

    assert_flag_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_holdoff) |-> !suspend_flag);

    assert_no_clock_without_osc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !clk_en);
endmodule

bind suspend_seq sseq_checker #(.NUM_IRQ_SRC(NUM_IRQ_SRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_wr       (ctl_wr),
    .ctl_suspend  (ctl_suspend),
    .irq_wake     (irq_wake),
    .dm_low       (dm_low),
    .osc_stable   (osc_stable),
    .instr_done   (instr_done),
    .clk_en       (clk_en),
    .osc_en       (osc_en),
    .timers_en    (timers_en),
    .irq_holdoff  (irq_holdoff),
    .suspend_flag (suspend_flag),
    .state        (state_q),
    .run_q        (run_q)
);

// File: tb/sim_suspend_seq.sv
// Self-checking bench for suspend_seq: a vector table walked by one loop,
// then directed tests for reset and corner cases.
module sim_suspend_seq;
    localparam int ID  = 3;
    localparam int ED  = 5;
    localparam int ELD = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0, ctl_suspend = 1'b0, ctl_run = 1'b0;
    logic [2:0] irq_wake = 3'b000;
    logic       dm_line = 1'b1;
    logic       osc_stable = 1'b0;
    logic       clk_ext = 1'b0, ext_long_dly = 1'b0;
    logic       instr_done = 1'b0;
    logic       clk_en, osc_en, timers_en, irq_holdoff, suspend_flag;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    suspend_seq #(.NUM_IRQ_SRC(3), .INT_DELAY(ID), .EXT_DELAY(ED), .EXT_LONG_DELAY(ELD)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_suspend(ctl_suspend),
        .ctl_run(ctl_run), .irq_wake(irq_wake), .dm_line(dm_line),
        .osc_stable(osc_stable), .clk_ext(clk_ext), .ext_long_dly(ext_long_dly),
        .instr_done(instr_done), .clk_en(clk_en), .osc_en(osc_en),
        .timers_en(timers_en), .irq_holdoff(irq_holdoff), .suspend_flag(suspend_flag)
    );

    // Vector fields: {clk_ext, ext_long_dly, source[1:0]}; source 3 = D- low.
    localparam logic [3:0] VEC [8] = '{
        4'b0000, 4'b0001, 4'b0010, 4'b0011,
        4'b0100, 4'b1001, 4'b1110, 4'b1111
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic s, input logic r);
        ctl_wr = 1'b1; ctl_suspend = s; ctl_run = r;
        tick();
        ctl_wr = 1'b0; ctl_suspend = 1'b0; ctl_run = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        int n;
        do_reset();
        // R1: reset state
        check("R1 clk_en", clk_en, 1);
        check("R1 osc_en", osc_en, 1);
        check("R1 timers_en", timers_en, 1);
        check("R1 irq_holdoff", irq_holdoff, 0);
        check("R1 suspend_flag", suspend_flag, 0);

        for (int i = 0; i < 8; i++) begin
            logic [1:0] src;
            int exp_dly;
            int exp_lat;
            src = VEC[i][1:0];
            clk_ext = VEC[i][3];
            ext_long_dly = VEC[i][2];
            exp_dly = !clk_ext ? ID : (ext_long_dly ? ELD : ED);
            exp_lat = (src == 2'd3) ? 3 : 1;
            osc_stable = 1'b0;
            write_ctl(1'b1, 1'b1);
            check("R2 clk_en gated", clk_en, 0);
            tick();
            check("R2 osc_en off", osc_en, 0);
            check("R9 flag set", suspend_flag, 1);
            if (src == 2'd3) dm_line = 1'b0;
            else irq_wake[src] = 1'b1;
            n = 0;
            while (!osc_en && n < 50) begin tick(); n++; end
            check("R4 wake latency", n, exp_lat);
            irq_wake = 3'b000;
            dm_line = 1'b1;
            osc_stable = 1'b1;
            n = 0;
            while (!clk_en && n < 50) begin tick(); n++; end
            check("R7 resume delay", n, exp_dly + 1);
            check("R8 holdoff on resume", irq_holdoff, 1);
            tick(); tick();
            check("R8 holdoff kept", irq_holdoff, 1);
            check("R9 flag kept", suspend_flag, 1);
            instr_done = 1'b1;
            tick();
            instr_done = 1'b0;
            check("R8 holdoff released", irq_holdoff, 0);
            check("R9 flag cleared", suspend_flag, 0);
            tick(); tick();
        end

        // R2: write without suspend has no effect
        clk_ext = 1'b0; ext_long_dly = 1'b0;
        write_ctl(1'b0, 1'b1);
        tick(); tick();
        check("R2 no-suspend clk_en", clk_en, 1);
        check("R2 no-suspend osc_en", osc_en, 1);
        check("R2 no-suspend flag", suspend_flag, 0);

        // R3: wake already pending at the suspend write
        osc_stable = 1'b0;
        irq_wake = 3'b001;
        write_ctl(1'b1, 1'b1);
        check("R3 clk_en gated", clk_en, 0);
        tick();
        check("R3 osc_en low once", osc_en, 0);
        tick();
        check("R3 osc_en back", osc_en, 1);
        irq_wake = 3'b000;
        // R6: long unstable oscillator keeps the clock off
        repeat (12) tick();
        check("R6 clk_en held", clk_en, 0);
        osc_stable = 1'b1;
        n = 0;
        while (!clk_en && n < 50) begin tick(); n++; end
        check("R7 internal delay after R3", n, ID + 1);
        instr_done = 1'b1;
        tick();
        instr_done = 1'b0;
        check("R8 release after R3", irq_holdoff, 0);

        // R5: run bit clear blocks every wake source
        osc_stable = 1'b1;
        write_ctl(1'b1, 1'b0);
        tick();
        irq_wake = 3'b111;
        dm_line = 1'b0;
        repeat (20) tick();
        check("R5 osc_en stays off", osc_en, 0);
        check("R5 clk_en stays off", clk_en, 0);
        irq_wake = 3'b000;
        dm_line = 1'b1;

        // R1: reset recovers from the stuck suspend
        do_reset();
        check("R1 clk_en after reset", clk_en, 1);
        check("R1 flag after reset", suspend_flag, 0);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule